// File: doc/BRIEF.md
# Three-Wire Half-Duplex SPI Master

This block is the host side of a serial link that uses a single bidirectional data line and a master-driven clock. A transaction starts with a strobe. The master shifts out a programmed number of bits taken from a transmit word FIFO. It then releases the data line and gives the peripheral time to take the bus. Next it clocks in a programmed number of bits, which are packed into 32-bit words in a receive FIFO. Last, it holds the clock low until the peripheral raises the data line to signal an event, and it answers that with a one-cycle interrupt to the host.

The state machine steps once every `CLK_DIV` system clocks in normal mode and once per system clock in fast mode. Fast mode adds an extra clock-high/clock-low pair to the turnaround, so the peripheral has enough time to release its input stage. Bit counts are loaded as "count minus one". Partly consumed transmit words and partly filled receive words carry over from one transaction to the next. The data input is used without a synchronizer, so the sample point keeps a fixed distance from the clock edge. The pad-side tristate is left to the integration: `dOut`, `dOe` and `dIn` are separate ports.

Top module: `spi3w_master`

## Requirements
- R1: After reset `sclk`, `dOe`, `irq` and `rxValid` are low and `txReady` is high.
- R2: The write phase sends `wrCount`+1 bits, most significant bit of each transmit word first. The design places one bit on `dOut` while `sclk` is low, and the bit stays stable for the whole clock-high step that follows. A transmit word is fetched only when the previous one is used up, so leftover bits serve the next transaction.
- R3: `dOe` rises with the first write step and stays high through the write phase. It falls only while `sclk` is low, right after the clock-high step of the last written bit.
- R4: In normal mode, the first read rising edge of `sclk` comes exactly 2×`CLK_DIV` system cycles after `dOe` falls: one release step plus one extra clock-low step.
- R5: In fast mode (one step per system clock), the turnaround adds a clock-high step followed by a clock-low step. A dummy `sclk` rise comes 1 cycle after `dOe` falls and the first read rise comes 3 cycles after. The read window holds `rdCount`+2 rises.
- R6: The read phase samples `dIn` at the end of each clock-high step, directly and with no synchronizer, for `rdCount`+1 bits. The first bit received goes to the most significant position. Every 32nd bit pushes a complete word to the receive FIFO, and words are pushed only while `dOe` is low.
- R7: A read of fewer than 32 bits pushes nothing. The bits wait and are completed by the next transaction's read bits.
- R8: After the read phase `sclk` stays low until `dIn` is seen high at a step. Then `irq` pulses high for exactly one system cycle, with `sclk` and `dOe` low, and the block returns to idle with no further clock activity.
- R9: A `start` strobe during a transaction has no effect. It changes neither the bit counts nor the sequence.
- R10: If the transmit FIFO is empty when a new word is needed, the write phase stalls with `sclk` low and `dOe` high until a word arrives.
- R11: `fastMode` is captured when `start` is accepted. Changing it during the transaction does not alter the turnaround.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fastMode | input | 1 | 1 = one step per system clock, 0 = one step per `CLK_DIV` clocks |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| wrCount | input | CNT_W | Number of bits to write, minus one |
| rdCount | input | CNT_W | Number of bits to read, minus one |
| txData | input | WORD | Transmit word |
| txValid | input | 1 | Push `txData` into the transmit FIFO |
| txReady | output | 1 | Transmit FIFO has room |
| rxData | output | WORD | Oldest received word |
| rxValid | output | 1 | Receive FIFO holds a word |
| rxReady | input | 1 | Pop the oldest received word |
| sclk | output | 1 | Serial clock |
| dOut | output | 1 | Data line output value |
| dOe | output | 1 | Data line output enable |
| dIn | input | 1 | Data line input value |
| irq | output | 1 | One-cycle event interrupt |

## Verification
The bench builds the block with `CLK_DIV`=3, `CNT_W`=8, `FIFO_DEPTH`=4 and a 32-bit word. The odd divider makes the normal-mode turnaround (6 cycles) clearly separate from the fast-mode one (1 and 3 cycles). It also shows that the step divider restarts on every accepted start. The 4-deep FIFOs with 16-, 32- and 64-bit transfers cover word fetch in the middle of a write, carry-over of half words in both directions, and the stall on an empty transmit FIFO.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_WR_LO,
    PH_WR_HI,
    PH_TA_REL,
    PH_TA_HI,
    PH_TA_LO,
    PH_RD_HI,
    PH_RD_LO,
    PH_EVT
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCnt;
    logic txPull;
    logic txStep;
    logic rxStep;
    logic yDec;
  } strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic txNeed;
    logic txAvail;
    logic wrLast;
    logic rdLast;
    logic rxStall;
  } status_t;

endpackage

// File: rtl/spi3w_fifo.sv
module spi3w_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] popData,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          doPush, doPop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign doPush  = push & ~full;
  assign doPop   = pop & ~empty;
  assign popData = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end
endmodule

// File: rtl/spi3w_ctrl.sv
module spi3w_ctrl
  import spi3w_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    fastMode,
  input  logic    dIn,
  input  status_t st,
  output strobe_t sb,
  output logic    sclk,
  output logic    dOe,
  output logic    irq
);
  localparam int DIVW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  phase_e        phase, phaseNxt;
  logic [DIVW-1:0] divCnt;
  logic          fastR, tick, irqSet;

  assign tick = fastR | (divCnt == DIVW'(CLK_DIV - 1));

  always_comb begin
    sb       = '0;
    phaseNxt = phase;
    irqSet   = 1'b0;
    unique case (phase)
      PH_IDLE:   if (start) begin
                   sb.loadCnt = 1'b1;
                   phaseNxt   = PH_WR_LO;
                 end
      PH_WR_LO:  begin
                   sb.txPull = st.txNeed & st.txAvail;
                   if (tick && !st.txNeed) phaseNxt = PH_WR_HI;
                 end
      PH_WR_HI:  if (tick) begin
                   sb.txStep = 1'b1;
                   phaseNxt  = st.wrLast ? PH_TA_REL : PH_WR_LO;
                 end
      PH_TA_REL: if (tick) phaseNxt = fastR ? PH_TA_HI : PH_TA_LO;
      PH_TA_HI:  if (tick) phaseNxt = PH_TA_LO;
      PH_TA_LO:  if (tick) phaseNxt = PH_RD_HI;
      PH_RD_HI:  if (tick && !st.rxStall) begin
                   sb.rxStep = 1'b1;
                   phaseNxt  = PH_RD_LO;
                 end
      PH_RD_LO:  if (tick) begin
                   sb.yDec  = 1'b1;
                   phaseNxt = st.rdLast ? PH_EVT : PH_RD_HI;
                 end
      PH_EVT:    if (tick && dIn) begin
                   irqSet   = 1'b1;
                   phaseNxt = PH_IDLE;
                 end
      default:   phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      divCnt <= '0;
      fastR  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      phase <= phaseNxt;
      irq   <= irqSet;
      if (phase == PH_IDLE) begin
        divCnt <= '0;
        if (start) fastR <= fastMode;
      end else begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    sclk = (phase == PH_WR_HI) || (phase == PH_TA_HI) || (phase == PH_RD_HI);
    dOe  = (phase == PH_WR_LO) || (phase == PH_WR_HI);
  end
endmodule

// File: rtl/spi3w_datapath.sv
module spi3w_datapath
  import spi3w_pkg::*;
#(
  parameter int WORD       = 32,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         sb,
  input  logic [CNT_W-1:0] wrCount,
  input  logic [CNT_W-1:0] rdCount,
  input  logic            dIn,
  input  logic [WORD-1:0] txData,
  input  logic            txValid,
  output logic            txReady,
  output logic [WORD-1:0] rxData,
  output logic            rxValid,
  input  logic            rxReady,
  output status_t         st,
  output logic            dOut
);
  localparam int BITW = $clog2(WORD + 1);
  localparam int RCW  = $clog2(WORD);

  logic [CNT_W-1:0] xCnt, yCnt;
  logic [WORD-1:0]  txShift, rxShift, rxNext, txHead;
  logic [BITW-1:0]  txLeft;
  logic [RCW-1:0]   rxCnt;
  logic             txEmpty, txFull, rxEmpty, rxFull, rxLastBit;

  spi3w_fifo #(.W(WORD), .DEPTH(FIFO_DEPTH)) txFifo (
    .clk(clk), .rstN(rstN),
    .push(txValid), .pushData(txData),
    .pop(sb.txPull), .popData(txHead),
    .empty(txEmpty), .full(txFull)
  );

  spi3w_fifo #(.W(WORD), .DEPTH(FIFO_DEPTH)) rxFifo (
    .clk(clk), .rstN(rstN),
    .push(sb.rxStep & rxLastBit), .pushData(rxNext),
    .pop(rxReady), .popData(rxData),
    .empty(rxEmpty), .full(rxFull)
  );

  assign txReady   = ~txFull;
  assign rxValid   = ~rxEmpty;
  assign rxLastBit = (rxCnt == RCW'(WORD - 1));
  assign rxNext    = {rxShift[WORD-2:0], dIn};
  assign dOut      = txShift[WORD-1];

  always_comb begin
    st.txNeed  = (txLeft == '0);
    st.txAvail = ~txEmpty;
    st.wrLast  = (xCnt == '0);
    st.rdLast  = (yCnt == '0);
    st.rxStall = rxLastBit & rxFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xCnt    <= '0;
      yCnt    <= '0;
      txShift <= '0;
      txLeft  <= '0;
      rxShift <= '0;
      rxCnt   <= '0;
    end else begin
      if (sb.loadCnt) begin
        xCnt <= wrCount;
        yCnt <= rdCount;
      end
      if (sb.txPull) begin
        txShift <= txHead;
        txLeft  <= BITW'(WORD);
      end else if (sb.txStep) begin
        txShift <= {txShift[WORD-2:0], 1'b0};
        txLeft  <= txLeft - 1'b1;
        xCnt    <= xCnt - 1'b1;
      end
      if (sb.rxStep) begin
        rxShift <= rxNext;
        rxCnt   <= rxCnt + 1'b1;
      end
      if (sb.yDec) yCnt <= yCnt - 1'b1;
    end
  end
endmodule

// File: rtl/spi3w_master.sv
module spi3w_master
  import spi3w_pkg::*;
#(
  parameter int WORD       = 32,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int CLK_DIV    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fastMode,
  input  logic             start,
  input  logic [CNT_W-1:0] wrCount,
  input  logic [CNT_W-1:0] rdCount,
  input  logic [WORD-1:0]  txData,
  input  logic             txValid,
  output logic             txReady,
  output logic [WORD-1:0]  rxData,
  output logic             rxValid,
  input  logic             rxReady,
  output logic             sclk,
  output logic             dOut,
  output logic             dOe,
  input  logic             dIn,
  output logic             irq
);
  strobe_t sb;
  status_t st;

  spi3w_ctrl #(.CLK_DIV(CLK_DIV)) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .fastMode(fastMode), .dIn(dIn),
    .st(st), .sb(sb), .sclk(sclk), .dOe(dOe), .irq(irq)
  );

  spi3w_datapath #(.WORD(WORD), .CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)) dp (
    .clk(clk), .rstN(rstN), .sb(sb), .wrCount(wrCount), .rdCount(rdCount),
    .dIn(dIn), .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .st(st), .dOut(dOut)
  );
endmodule

// File: rtl/spi3w_master_chk.sv
module spi3w_master_chk (
  input logic clk,
  input logic rstN,
  input logic sclk,
  input logic dOut,
  input logic dOe,
  input logic irq,
  input logic rxValid
);
  // R2
  dout_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dOe && sclk && $past(sclk)) |-> $stable(dOut));

  // R3
  release_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dOe) |-> !sclk);

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (!sclk && !dOe));

  // R6
  rx_push_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValid) |-> !dOe);
endmodule

bind spi3w_master spi3w_master_chk chkInst (
  .clk(clk), .rstN(rstN), .sclk(sclk), .dOut(dOut),
  .dOe(dOe), .irq(irq), .rxValid(rxValid)
);

// File: tb/spi3w_master_test.sv
module spi3w_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int WORD = 32;
  localparam int CNT_W = 8;
  localparam int CLK_DIV = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic fastMode = 1'b0, start = 1'b0, txValid = 1'b0, rxReady = 1'b0, dIn = 1'b0;
  logic [CNT_W-1:0] wrCount = '0, rdCount = '0;
  logic [WORD-1:0] txData = '0, rxData;
  logic txReady, rxValid, sclk, dOut, dOe, irq;

  spi3w_master #(.WORD(WORD), .CNT_W(CNT_W), .FIFO_DEPTH(4), .CLK_DIV(CLK_DIV)) uut (
    .clk(clk), .rstN(rstN), .fastMode(fastMode), .start(start),
    .wrCount(wrCount), .rdCount(rdCount), .txData(txData), .txValid(txValid),
    .txReady(txReady), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .sclk(sclk), .dOut(dOut), .dOe(dOe), .dIn(dIn), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, failed = 0;

  // expected bit streams (task-owned)
  logic expTx [0:1023];
  logic expRx [0:1023];
  int txN = 0, txPtr = 0, rxN = 0, rxPtr = 0;
  logic [63:0] rdPat = '0;
  int rdNeed = 0, rdDummy = 0, irqBase = 0, evtReqN = 0;

  // monitor state (monitor-owned)
  logic wrGot [0:255];
  int cyc = 0, wrSeen = 0, rdRises = 0, oeFallCyc = 0, riseD0 = -1, riseDRead = -1;
  int irqCnt = 0, strayRises = 0;
  logic readWin = 1'b0, doneRead = 1'b0, prevSclk = 1'b0, prevOe = 1'b0;

  always @(negedge clk) begin : mon
    int k;
    cyc++;
    if (!prevOe && dOe) begin
      wrSeen = 0;
      doneRead = 1'b0;
    end
    if (prevOe && !dOe) begin
      readWin = 1'b1; oeFallCyc = cyc; rdRises = 0; riseD0 = -1; riseDRead = -1;
    end
    if (sclk && !prevSclk) begin
      if (dOe) begin
        wrGot[wrSeen] = dOut;
        wrSeen++;
      end else if (readWin) begin
        if (rdRises == 0) riseD0 = cyc - oeFallCyc;
        k = rdRises - rdDummy;
        if (k == 0) riseDRead = cyc - oeFallCyc;
        if (k >= 0 && k < rdNeed) dIn = rdPat[63-k];
        rdRises++;
      end else begin
        strayRises++;
      end
    end
    if (!sclk && prevSclk && readWin && !dOe && rdRises == rdDummy + rdNeed) begin
      dIn = 1'b0;
      doneRead = 1'b1;
    end
    if (irq) begin
      irqCnt++;
      readWin = 1'b0;
      dIn = 1'b0;
    end else if (evtReqN > irqCnt) begin
      dIn = 1'b1;
    end
    prevSclk = sclk;
    prevOe = dOe;
  end

  task automatic chkEq(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pushTx(input logic [WORD-1:0] w);
    @(negedge clk);
    chkEq("R2", "txReady before push", txReady, 1);
    txData = w; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    for (int i = WORD - 1; i >= 0; i--) begin
      expTx[txN] = w[i];
      txN++;
    end
  endtask

  task automatic startXfer(input logic fast, input int wr, input int rd, input logic [63:0] pat);
    rdPat = pat; rdNeed = rd + 1; rdDummy = fast ? 1 : 0; irqBase = irqCnt;
    @(negedge clk);
    fastMode = fast; wrCount = CNT_W'(wr); rdCount = CNT_W'(rd); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finishXfer(input string req, input int wr);
    int mism;
    int n;
    n = 0;
    while (!doneRead && n < 5000) begin @(negedge clk); n++; end
    chkEq(req, "read phase completed", doneRead, 1);
    repeat (4 * CLK_DIV) @(negedge clk);
    chkEq("R8", "no irq before event", irqCnt, irqBase);
    chkEq("R8", "sclk low while waiting", sclk, 0);
    evtReqN++;
    n = 0;
    while (irqCnt == irqBase && n < 40) begin @(negedge clk); n++; end
    chkEq("R8", "irq after event", irqCnt, irqBase + 1);
    @(negedge clk);
    chkEq("R8", "irq single cycle", irq, 0);
    chkEq(req, "read rises", rdRises, rdNeed + rdDummy);
    chkEq("R2", "written bit count", wrSeen, wr + 1);
    mism = 0;
    for (int i = 0; i < wrSeen && i <= wr; i++)
      if (wrGot[i] !== expTx[txPtr + i]) mism++;
    chkEq("R2", "written bit mismatches", mism, 0);
    txPtr += wr + 1;
    for (int i = 0; i < rdNeed; i++) begin
      expRx[rxN] = rdPat[63-i];
      rxN++;
    end
  endtask

  task automatic drainRx(input string req);
    logic [WORD-1:0] w;
    while (rxN - rxPtr >= WORD) begin
      for (int i = 0; i < WORD; i++) w[WORD-1-i] = expRx[rxPtr + i];
      @(negedge clk);
      chkEq(req, "rx word present", rxValid, 1);
      chkEq(req, "rx word value", rxData, w);
      rxReady = 1'b1;
      @(negedge clk);
      rxReady = 1'b0;
      rxPtr += WORD;
    end
    @(negedge clk);
    chkEq(req, "no extra rx word", rxValid, 0);
  endtask

  task automatic testReset;
    chkEq("R1", "sclk", sclk, 0);
    chkEq("R1", "dOe", dOe, 0);
    chkEq("R1", "irq", irq, 0);
    chkEq("R1", "rxValid", rxValid, 0);
    chkEq("R1", "txReady", txReady, 1);
  endtask

  task automatic testNormal;
    pushTx(32'hA5C3_0F96);
    pushTx(32'h1234_FEDC);
    startXfer(1'b0, 63, 31, 64'hC0DE_5A71_0000_0000);
    finishXfer("R6", 63);
    chkEq("R4", "dOe fall to first read rise", riseD0, 2 * CLK_DIV);
    chkEq("R3", "dOe low after transaction", dOe, 0);
    drainRx("R6");
  endtask

  task automatic testFast;
    pushTx(32'h8000_0001);
    startXfer(1'b1, 31, 63, 64'hF00D_BEEF_3C69_0A55);
    finishXfer("R5", 31);
    chkEq("R5", "dummy rise delay", riseD0, 1);
    chkEq("R5", "first read rise delay", riseDRead, 3);
    drainRx("R6");
  endtask

  task automatic testCarry;
    pushTx(32'h6B2E_91D4);
    startXfer(1'b0, 15, 15, 64'hE17A_0000_0000_0000);
    finishXfer("R7", 15);
    @(negedge clk);
    chkEq("R7", "half word not pushed", rxValid, 0);
    startXfer(1'b1, 15, 15, 64'h4C93_0000_0000_0000);
    finishXfer("R7", 15);
    drainRx("R7");
  endtask

  task automatic testStartIgnored;
    int strays0;
    pushTx(32'h0F0F_3333);
    startXfer(1'b0, 31, 31, 64'h9ABC_DEF0_0000_0000);
    @(negedge clk);
    wrCount = CNT_W'(5); rdCount = CNT_W'(3); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finishXfer("R9", 31);
    strays0 = strayRises;
    repeat (30) @(negedge clk);
    chkEq("R9", "no clock after irq", strayRises, strays0);
    chkEq("R9", "line released after irq", dOe, 0);
    drainRx("R9");
  endtask

  task automatic testStall;
    startXfer(1'b1, 31, 31, 64'h1357_9BDF_0000_0000);
    repeat (20) @(negedge clk);
    chkEq("R10", "sclk low in stall", sclk, 0);
    chkEq("R10", "dOe high in stall", dOe, 1);
    chkEq("R10", "no bits during stall", wrSeen, 0);
    pushTx(32'hDEAD_0042);
    finishXfer("R10", 31);
    drainRx("R10");
  endtask

  task automatic testModeLatch;
    pushTx(32'h7E81_24C3);
    startXfer(1'b1, 31, 31, 64'h2468_ACE0_0000_0000);
    fastMode = 1'b0;
    finishXfer("R11", 31);
    chkEq("R11", "dummy rise delay kept", riseD0, 1);
    chkEq("R11", "read rise delay kept", riseDRead, 3);
    drainRx("R11");
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset;
    testNormal;
    testFast;
    testCarry;
    testStartIgnored;
    testStall;
    testModeLatch;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule